// File: doc/BRIEF.md
# Ethernet Destination Address Filter

This block sits at the front of a receive path and looks only at the first six octets of each incoming frame, which carry the destination address. From them it decides whether the frame should be kept. Three kinds of address can pass. The first is an exact match with the station's own address. The second is the all-ones broadcast address. The third is a group (multicast) address whose hash selects a set bit in a 64-bit group mask. A promiscuous setting overrides all of these. CRC checking of the frame and storage of the frame are handled elsewhere.

Octets arrive one per cycle when `in_valid` is high, and the first octet of a frame is marked with `in_sof`. The octet stream may contain idle cycles. A 32-bit CRC is built up octet by octet while the address arrives, so the hash index is ready when the sixth octet is taken. The decision is then presented as a single-cycle pulse together with class flags. Octets after the address field are ignored until the next start of frame.

Top module: `dest_addr_filter`

## Requirements
- R1: After reset, and until a decision is made, `dec_valid`, `dec_accept`, `dec_mcast` and `dec_bcast` are all 0.
- R2: A frame whose six address octets equal `station_addr` is accepted. The first received octet is compared with `station_addr[47:40]` and the sixth with `station_addr[7:0]`.
- R3: An all-ones destination sets `dec_bcast`. It is accepted when `cfg_bcast_en` is 1 and rejected when it is 0, unless promiscuous mode is on.
- R4: A destination whose first octet has bit 0 set, and which is not all ones, sets `dec_mcast`. It is accepted only when `cfg_mcast_en` is 1 and `group_mask[idx]` is 1. Addresses in the IP group range 01:00:5E:00:00:00 to 01:00:5E:7F:FF:FF follow this rule like any other group address.
- R5: The hash index is computed as follows. A 32-bit register starts at all ones. For each octet, bit 0 first, each bit is shifted in: fb = reg[0] xor bit, reg = reg >> 1, and if fb is 1 then reg ^= 0xEDB88320. After the sixth octet, idx = reg[31:26], with no final inversion.
- R6: When `cfg_promisc` is 1, every frame of at least six octets is accepted.
- R7: `dec_valid` pulses for exactly one cycle, in the cycle after the sixth address octet is taken. It stays 0 while the address is arriving, during idle gaps and for all octets after the address.
- R8: If `in_eof` marks an octet before the sixth, `dec_valid` pulses in the next cycle with `dec_accept`, `dec_mcast` and `dec_bcast` all 0. This holds even in promiscuous mode.
- R9: An octet with `in_sof` set always restarts address collection at octet 0, so a partially received address is discarded without any decision.
- R10: Whenever `dec_valid` is 0, `dec_accept`, `dec_mcast` and `dec_bcast` are 0, and `dec_mcast` and `dec_bcast` are never 1 together.
- R11: With promiscuous mode off, a non-group destination that differs from `station_addr` in any bit is rejected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | An octet is present on `in_data` |
| in_sof | input | 1 | This octet is the first of a frame |
| in_eof | input | 1 | This octet is the last of a frame |
| in_data | input | 8 | Received octet |
| station_addr | input | 48 | Own address; bits [47:40] are the first octet on the wire |
| group_mask | input | 64 | Group hash mask, indexed by the 6-bit hash |
| cfg_bcast_en | input | 1 | Accept the broadcast address |
| cfg_mcast_en | input | 1 | Accept group addresses that hit the mask |
| cfg_promisc | input | 1 | Accept every full-length frame |
| dec_valid | output | 1 | One-cycle decision strobe |
| dec_accept | output | 1 | Frame is to be kept |
| dec_mcast | output | 1 | Destination is a non-broadcast group address |
| dec_bcast | output | 1 | Destination is the broadcast address |

## Verification
The bench drives addresses of five kinds: the station address, the same address with one bit changed, all ones, random group addresses including the IP group range, and random unicast. These separate the exact-compare path, the broadcast path and the hashed-mask path from each other. Mask bits are set and cleared at the exact index computed by the bench. This shows that the CRC hash picks the right mask bit rather than a neighbouring one. Frames with idle gaps, trailing octets, early end of frame and restarts partway through the address expose any miscounting of octet position or decision timing.

// File: rtl/daf_pkg.sv
package daf_pkg;
  localparam int OCTET_W = 8;
  localparam int CRC_W = 32;
  localparam logic [CRC_W-1:0] CRC_POLY_R = 32'hEDB88320;
  localparam logic [CRC_W-1:0] CRC_SEED = '1;

  typedef logic [OCTET_W-1:0] octet_t;

  typedef struct packed {
    logic uc;   // all octets so far equal the station address
    logic bc;   // all octets so far are all ones
    logic grp;  // group bit of the first octet
  } addr_class_t;

  // one octet through the reflected CRC-32, LSB first
  function automatic logic [CRC_W-1:0] crc_octet(input logic [CRC_W-1:0] c,
                                                 input octet_t d);
    logic [CRC_W-1:0] r;
    logic fb;
    r = c;
    for (int i = 0; i < OCTET_W; i++) begin
      fb = r[0] ^ d[i];
      r = r >> 1;
      if (fb) r = r ^ CRC_POLY_R;
    end
    return r;
  endfunction
endpackage

// File: rtl/daf_pos.sv
module daf_pos #(
  parameter int ADDR_BYTES = 6,
  localparam int CNT_W = $clog2(ADDR_BYTES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             in_sof,
  input  logic             in_eof,
  output logic             byte_take,
  output logic             first_byte,
  output logic [CNT_W-1:0] pos,
  output logic             evt_last,
  output logic             evt_short
);
  localparam logic [CNT_W-1:0] LAST_POS = CNT_W'(ADDR_BYTES - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             active;

  assign active     = (cnt_q != '0);
  assign first_byte = in_valid & in_sof;
  assign byte_take  = in_valid & (in_sof | active);
  assign pos        = in_sof ? '0 : cnt_q;
  assign evt_last   = byte_take & (pos == LAST_POS);
  assign evt_short  = byte_take & in_eof & (pos != LAST_POS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (byte_take) begin
      if (evt_last || evt_short) cnt_q <= '0;
      else                       cnt_q <= pos + 1'b1;
    end
  end
endmodule

// File: rtl/daf_match.sv
module daf_match
  import daf_pkg::*;
#(
  parameter int ADDR_BYTES = 6,
  localparam int CNT_W = $clog2(ADDR_BYTES),
  localparam int ADDR_W = ADDR_BYTES * OCTET_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_take,
  input  logic              first_byte,
  input  logic [CNT_W-1:0]  pos,
  input  octet_t            in_data,
  input  logic [ADDR_W-1:0] station_addr,
  output addr_class_t       cls_nxt
);
  addr_class_t cls_q;
  octet_t      st_octet;

  // octet 0 is the most significant octet of station_addr
  always_comb begin
    st_octet = station_addr[(ADDR_BYTES - 1 - int'(pos)) * OCTET_W +: OCTET_W];
  end

  always_comb begin
    cls_nxt.uc  = (first_byte | cls_q.uc) & (in_data == st_octet);
    cls_nxt.bc  = (first_byte | cls_q.bc) & (&in_data);
    cls_nxt.grp = first_byte ? in_data[0] : cls_q.grp;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cls_q <= '0;
    else if (byte_take) cls_q <= cls_nxt;
  end
endmodule

// File: rtl/daf_hash.sv
module daf_hash
  import daf_pkg::*;
#(
  parameter int HASH_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_take,
  input  logic              first_byte,
  input  octet_t            in_data,
  output logic [HASH_W-1:0] hash_idx
);
  logic [CRC_W-1:0] crc_q;
  logic [CRC_W-1:0] crc_nxt;

  assign crc_nxt  = crc_octet(first_byte ? CRC_SEED : crc_q, in_data);
  assign hash_idx = crc_nxt[CRC_W-1 -: HASH_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         crc_q <= CRC_SEED;
    else if (byte_take) crc_q <= crc_nxt;
  end
endmodule

// File: rtl/daf_decide.sv
module daf_decide
  import daf_pkg::*;
#(
  parameter int MASK_BITS = 64,
  localparam int HASH_W = $clog2(MASK_BITS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 evt_last,
  input  logic                 evt_short,
  input  addr_class_t          cls_nxt,
  input  logic [HASH_W-1:0]    hash_idx,
  input  logic [MASK_BITS-1:0] group_mask,
  input  logic                 cfg_bcast_en,
  input  logic                 cfg_mcast_en,
  input  logic                 cfg_promisc,
  output logic                 hash_hit,
  output logic                 dec_valid,
  output logic                 dec_accept,
  output logic                 dec_mcast,
  output logic                 dec_bcast
);
  logic is_bc, is_mc, take_it;

  assign hash_hit = group_mask[hash_idx];
  assign is_bc    = cls_nxt.bc;
  assign is_mc    = cls_nxt.grp & ~cls_nxt.bc;
  assign take_it  = cfg_promisc
                  | (cls_nxt.uc & ~cls_nxt.grp)
                  | (is_bc & cfg_bcast_en)
                  | (is_mc & cfg_mcast_en & hash_hit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dec_valid  <= 1'b0;
      dec_accept <= 1'b0;
      dec_mcast  <= 1'b0;
      dec_bcast  <= 1'b0;
    end else begin
      dec_valid  <= evt_last | evt_short;
      dec_accept <= evt_last & take_it;
      dec_mcast  <= evt_last & is_mc;
      dec_bcast  <= evt_last & is_bc;
    end
  end
endmodule

// File: rtl/dest_addr_filter.sv
module dest_addr_filter
  import daf_pkg::*;
#(
  parameter int ADDR_BYTES = 6,
  parameter int MASK_BITS = 64,
  localparam int ADDR_W = ADDR_BYTES * OCTET_W,
  localparam int CNT_W = $clog2(ADDR_BYTES),
  localparam int HASH_W = $clog2(MASK_BITS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic                 in_sof,
  input  logic                 in_eof,
  input  logic [7:0]           in_data,
  input  logic [ADDR_W-1:0]    station_addr,
  input  logic [MASK_BITS-1:0] group_mask,
  input  logic                 cfg_bcast_en,
  input  logic                 cfg_mcast_en,
  input  logic                 cfg_promisc,
  output logic                 dec_valid,
  output logic                 dec_accept,
  output logic                 dec_mcast,
  output logic                 dec_bcast
);
  logic              byte_take;
  logic              first_byte;
  logic [CNT_W-1:0]  pos;
  logic              evt_last;
  logic              evt_short;
  addr_class_t       cls_nxt;
  logic [HASH_W-1:0] hash_idx;
  logic              hash_hit;

  daf_pos #(.ADDR_BYTES(ADDR_BYTES)) u_pos (
    .clk, .rst_n, .in_valid, .in_sof, .in_eof,
    .byte_take, .first_byte, .pos, .evt_last, .evt_short
  );

  daf_match #(.ADDR_BYTES(ADDR_BYTES)) u_match (
    .clk, .rst_n, .byte_take, .first_byte, .pos,
    .in_data, .station_addr, .cls_nxt
  );

  daf_hash #(.HASH_W(HASH_W)) u_hash (
    .clk, .rst_n, .byte_take, .first_byte, .in_data, .hash_idx
  );

  daf_decide #(.MASK_BITS(MASK_BITS)) u_decide (
    .clk, .rst_n, .evt_last, .evt_short, .cls_nxt, .hash_idx,
    .group_mask, .cfg_bcast_en, .cfg_mcast_en, .cfg_promisc,
    .hash_hit, .dec_valid, .dec_accept, .dec_mcast, .dec_bcast
  );
endmodule

// File: rtl/daf_checker.sv
module daf_checker (
  input logic clk,
  input logic rst_n,
  input logic evt_last,
  input logic evt_short,
  input logic cfg_promisc,
  input logic cfg_bcast_en,
  input logic dec_valid,
  input logic dec_accept,
  input logic dec_mcast,
  input logic dec_bcast
);
  // R7
  last_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_last |=> dec_valid);

  // R8
  short_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_short |=> (dec_valid && !dec_accept && !dec_mcast && !dec_bcast));

  // R10
  quiet_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_valid |-> (!dec_accept && !dec_mcast && !dec_bcast));

  // R10
  class_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(dec_mcast && dec_bcast));

  // R6
  promisc_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_last && cfg_promisc) |=> dec_accept);

  // R3
  bcast_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_last && cfg_bcast_en) |=> (dec_bcast |-> dec_accept));
endmodule

bind dest_addr_filter daf_checker u_chk (
  .clk(clk), .rst_n(rst_n), .evt_last(evt_last), .evt_short(evt_short),
  .cfg_promisc(cfg_promisc), .cfg_bcast_en(cfg_bcast_en),
  .dec_valid(dec_valid), .dec_accept(dec_accept),
  .dec_mcast(dec_mcast), .dec_bcast(dec_bcast)
);

// File: tb/dest_addr_filter_bench.sv
module dest_addr_filter_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0;
  logic [7:0]  in_data = '0;
  logic [47:0] station_addr = 48'h02_1A_33_C4_5E_97;
  logic [63:0] group_mask = '0;
  logic        cfg_bcast_en = 1'b1, cfg_mcast_en = 1'b1, cfg_promisc = 1'b0;
  logic        dec_valid, dec_accept, dec_mcast, dec_bcast;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  dest_addr_filter u_dest_addr_filter (
    .clk, .rst_n, .in_valid, .in_sof, .in_eof, .in_data,
    .station_addr, .group_mask, .cfg_bcast_en, .cfg_mcast_en, .cfg_promisc,
    .dec_valid, .dec_accept, .dec_mcast, .dec_bcast
  );

  function automatic logic [5:0] ref_idx(input logic [47:0] a);
    logic [31:0] r = 32'hFFFF_FFFF;
    for (int k = 0; k < 48; k++) begin
      logic b = a[47 - 8*(k/8) - 7 + (k%8)];
      r = (r[0] ^ b) ? ((r >> 1) ^ 32'hEDB88320) : (r >> 1);
    end
    return r[31:26];
  endfunction

  function automatic logic ref_bc(input logic [47:0] a);
    return a == 48'hFFFF_FFFF_FFFF;
  endfunction

  function automatic logic ref_mc(input logic [47:0] a);
    return a[40] && !ref_bc(a);
  endfunction

  function automatic logic ref_acc(input logic [47:0] a);
    if (cfg_promisc) return 1'b1;
    if (ref_bc(a)) return cfg_bcast_en;
    if (a[40]) return cfg_mcast_en && group_mask[ref_idx(a)];
    return a == station_addr;
  endfunction

  task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual(v,acc,mc,bc)=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic put_byte(input logic [7:0] d, input logic s, input logic e);
    in_valid = 1'b1; in_sof = s; in_eof = e; in_data = d;
    @(negedge clk);
    in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
  endtask

  task automatic run_frame(input logic [47:0] a, input int len, input bit gaps,
                           input string tag);
    logic [3:0] exp_full;
    exp_full = {1'b1, ref_acc(a), ref_mc(a), ref_bc(a)};
    for (int k = 0; k < len; k++) begin
      if (gaps && k > 0 && $urandom_range(0, 2) == 0) begin
        @(negedge clk);
        check("R7 gap", {dec_valid, dec_accept, dec_mcast, dec_bcast}, 4'b0000);
      end
      put_byte(k < 6 ? a[47 - 8*k -: 8] : 8'($urandom), k == 0, k == len - 1);
      if (k == 5)
        check(tag, {dec_valid, dec_accept, dec_mcast, dec_bcast}, exp_full);
      else if (k < 5 && k == len - 1)
        check("R8 short", {dec_valid, dec_accept, dec_mcast, dec_bcast}, 4'b1000);
      else
        check("R7 no strobe", {dec_valid, dec_accept, dec_mcast, dec_bcast}, 4'b0000);
    end
    @(negedge clk);
    check("R10 idle", {dec_valid, dec_accept, dec_mcast, dec_bcast}, 4'b0000);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL R7 watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [47:0] a;
    logic [5:0]  ix;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    check("R1 in reset", {dec_valid, dec_accept, dec_mcast, dec_bcast}, 4'b0000);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after reset", {dec_valid, dec_accept, dec_mcast, dec_bcast}, 4'b0000);

    run_frame(station_addr, 8, 1'b0, "R2 own address");
    run_frame(station_addr ^ 48'h1, 6, 1'b1, "R11 last bit differs");
    run_frame(station_addr ^ 48'h0000_8000_0000, 7, 1'b0, "R11 mid bit differs");
    run_frame('1, 6, 1'b0, "R3 broadcast on");
    cfg_bcast_en = 1'b0;
    run_frame('1, 9, 1'b1, "R3 broadcast off");
    cfg_bcast_en = 1'b1;

    a = 48'h01_00_5E_12_34_56; ix = ref_idx(a);
    group_mask = '0; group_mask[ix] = 1'b1;
    run_frame(a, 6, 1'b0, "R4 R5 IP group hit");
    group_mask = '1; group_mask[ix] = 1'b0;
    run_frame(a, 6, 1'b0, "R4 R5 IP group miss");
    group_mask = '1;
    cfg_mcast_en = 1'b0;
    run_frame(48'h33_00_00_00_00_01, 6, 1'b0, "R4 group disabled");
    cfg_mcast_en = 1'b1;

    cfg_promisc = 1'b1;
    run_frame(48'h0A_BB_CC_DD_EE_FF, 6, 1'b1, "R6 promiscuous");
    run_frame(station_addr, 4, 1'b0, "R8 short promisc");
    run_frame('1, 1, 1'b0, "R8 one octet");
    cfg_promisc = 1'b0;

    // restart inside the address field
    for (int k = 0; k < 3; k++) begin
      put_byte(8'hFF, k == 0, 1'b0);
      check("R9 partial", {dec_valid, dec_accept, dec_mcast, dec_bcast}, 4'b0000);
    end
    run_frame(station_addr, 6, 1'b0, "R9 restart own");

    for (int n = 0; n < 400; n++) begin
      int kind = $urandom_range(0, 5);
      string tag;
      group_mask   = {$urandom, $urandom};
      cfg_bcast_en = 1'($urandom);
      cfg_mcast_en = 1'($urandom);
      cfg_promisc  = ($urandom_range(0, 7) == 0);
      case (kind)
        0: begin a = station_addr; tag = "R2 rnd own"; end
        1: begin a = station_addr ^ (48'h1 << $urandom_range(0, 47)); tag = "R11 rnd flip"; end
        2: begin a = '1; tag = "R3 rnd bcast"; end
        3: begin a = {24'h01_00_5E, 1'b0, 23'($urandom)}; tag = "R4 rnd IP group"; end
        4: begin a = {$urandom, 16'($urandom)}; a[40] = 1'b1; tag = "R5 rnd group"; end
        default: begin a = {$urandom, 16'($urandom)}; a[40] = 1'b0; tag = "R11 rnd unicast"; end
      endcase
      if (cfg_promisc) tag = "R6 rnd promisc";
      run_frame(a, ($urandom_range(0, 9) == 0) ? $urandom_range(1, 5) : $urandom_range(6, 12),
                $urandom_range(0, 1) == 1, tag);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule